// File: doc/BRIEF.md
# Cache Peripheral Sleep Controller

This controller decides when the peripheral circuits of the first- and second-level caches (wordline drivers, address and data drivers) may drop into a low-leakage sleep mode. Its trigger is a miss in the last-level cache. Such a miss is serviced after a fixed, known number of cycles. Once the miss is outstanding, the controller watches the core for a run of cycles in which nothing is issued and nothing executes. When that run is long enough, it raises a sleep signal to the cache peripherals.

The service time of the miss is deterministic, so the controller can lower sleep on a schedule rather than waiting for the data. It releases sleep a fixed number of cycles before the miss data returns. That lead time is chosen to cover the wakeup latency of the sleep transistors, so the caches are ready again when the core resumes and the stall costs nothing. A one-cycle pulse marks each wakeup.

Top module: `cache_sleep_ctrl`

## Requirements
- R1: While no miss is outstanding, idle cycles are not counted and `sleep` stays low.
- R2: A cycle is idle only when `iq_issue` and `fu_exec` are both low; either one high on its own makes the cycle active.
- R3: With a miss outstanding, `sleep` goes high in the cycle after the IDLE_K-th consecutive idle cycle has been sampled. With defaults, after a miss sampled at edge 0 and idle cycles from then on, `sleep` is first high after edge 10.
- R4: An active cycle before the threshold is reached restarts the idle count from zero.
- R5: `sleep` goes low once the cycles left until the miss returns are WAKE_LEAD or fewer. With defaults, this is after edge MISS_LAT-WAKE_LEAD = 290 counted from the latest miss.
- R6: If the cycles left when the idle threshold is reached are WAKE_LEAD or fewer, `sleep` is not raised for that miss.
- R7: A miss that arrives while another is outstanding restarts the service countdown at MISS_LAT from its own edge, and the earlier countdown is dropped.
- R8: An active cycle while `sleep` is high lowers `sleep` at the next edge. Sleep can only be entered again after a fresh run of IDLE_K idle cycles.
- R9: `wake_done` is high for exactly one cycle, the first cycle in which `sleep` is low after having been high, and is low at all other times.
- R10: While `rst_n` is low, `sleep` and `wake_done` are low at once and all counters are cleared, so no miss is outstanding after reset.
- R11: A miss is serviced MISS_LAT edges after it is sampled. After that, further idle cycles do not raise `sleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| miss_start | input | 1 | One-cycle pulse when a last-level cache miss is issued |
| iq_issue | input | 1 | The instruction queue issued at least one instruction this cycle |
| fu_exec | input | 1 | At least one functional unit executed an instruction this cycle |
| sleep | output | 1 | Puts the cache peripheral circuits into low-leakage mode while high |
| wake_done | output | 1 | One-cycle pulse in the first cycle after sleep is released |

## Verification
A wrong idle count shows up at `sleep` as an entry that is one or more cycles early or late relative to the tenth idle edge. The same fault can also show up as an entry that survives an active cycle. A wrong service countdown moves the falling edge of `sleep` and the `wake_done` pulse away from edge 290 after the latest miss, or lets sleep be entered after the miss has returned. Because the bench compares `sleep` and `wake_done` in every cycle of every scenario, such a fault is reported in the first cycle in which the outputs diverge.

// File: rtl/slp_pkg.sv
package slp_pkg;
  // Power state of the cache peripherals as seen by the controller.
  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } slp_state_e;

  localparam int DEF_IDLE_K    = 10;
  localparam int DEF_MISS_LAT  = 300;
  localparam int DEF_WAKE_LEAD = 10;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/slp_miss_timer.sv
module slp_miss_timer #(
  parameter int MISS_LAT = 300,
  parameter int REM_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_start,
  output logic             pend_q,
  output logic             pend_d,
  output logic [REM_W-1:0] rem_q,
  output logic [REM_W-1:0] rem_d
);
  localparam logic [REM_W-1:0] LAT_V = REM_W'(MISS_LAT);
  localparam logic [REM_W-1:0] ONE_V = REM_W'(1);

  logic adv;

  // A new miss always restarts the countdown; otherwise count down to return.
  always_comb begin
    pend_d = pend_q;
    rem_d  = rem_q;
    if (miss_start) begin
      pend_d = 1'b1;
      rem_d  = LAT_V;
    end else if (pend_q) begin
      rem_d  = rem_q - ONE_V;
      pend_d = (rem_q != ONE_V);
    end
  end

  assign adv = miss_start | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rem_q  <= '0;
    end else if (adv) begin
      pend_q <= pend_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/slp_idle_mon.sv
module slp_idle_mon #(
  parameter int IDLE_K = 10,
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_q,
  input  logic              iq_issue,
  input  logic              fu_exec,
  output logic [IDLE_W-1:0] idle_q,
  output logic [IDLE_W-1:0] idle_d
);
  localparam logic [IDLE_W-1:0] K_V   = IDLE_W'(IDLE_K);
  localparam logic [IDLE_W-1:0] ONE_V = IDLE_W'(1);

  logic active;
  logic en;

  assign active = iq_issue | fu_exec;

  // Saturating run length of idle cycles, counted only while a miss is open.
  always_comb begin
    if (!pend_q || active) idle_d = '0;
    else if (idle_q == K_V) idle_d = K_V;
    else                    idle_d = idle_q + ONE_V;
  end

  assign en = pend_q | (idle_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idle_q <= '0;
    else if (en) idle_q <= idle_d;
  end
endmodule

// File: rtl/slp_sleep_ctl.sv
module slp_sleep_ctl import slp_pkg::*; #(
  parameter int IDLE_K    = 10,
  parameter int MISS_LAT  = 300,
  parameter int WAKE_LEAD = 10,
  parameter int IDLE_W    = 4,
  parameter int REM_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_d,
  input  logic [IDLE_W-1:0] idle_d,
  input  logic [REM_W-1:0]  rem_d,
  output logic              sleep,
  output logic              wake_done
);
  localparam logic [IDLE_W-1:0] K_V = IDLE_W'(IDLE_K);

  slp_state_e st_q, st_d;
  logic       sleep_ok;
  logic       wake_d;

  // Sleep is a registered function of the next-state counters, so it
  // changes on the same edge as the counters that justify it.
  generate
    if (WAKE_LEAD >= MISS_LAT) begin : g_never
      assign sleep_ok = 1'b0;
    end else begin : g_sched
      localparam logic [REM_W-1:0] LEAD_V = REM_W'(WAKE_LEAD);
      assign sleep_ok = pend_d && (idle_d == K_V) && (rem_d > LEAD_V);
    end
  endgenerate

  always_comb begin
    st_d   = sleep_ok ? ST_ASLEEP : ST_AWAKE;
    wake_d = (st_q == ST_ASLEEP) && !sleep_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_AWAKE;
      wake_done <= 1'b0;
    end else begin
      st_q      <= st_d;
      wake_done <= wake_d;
    end
  end

  assign sleep = (st_q == ST_ASLEEP);
endmodule

// File: rtl/cache_sleep_ctrl.sv
module cache_sleep_ctrl import slp_pkg::*; #(
  parameter int IDLE_K    = DEF_IDLE_K,
  parameter int MISS_LAT  = DEF_MISS_LAT,
  parameter int WAKE_LEAD = DEF_WAKE_LEAD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_start,
  input  logic iq_issue,
  input  logic fu_exec,
  output logic sleep,
  output logic wake_done
);
  localparam int IDLE_W = $clog2(IDLE_K + 1);
  localparam int REM_W  = $clog2(MISS_LAT + 1);

  logic              rst_n_s;
  logic              pend_q, pend_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [IDLE_W-1:0] idle_q, idle_d;

  slp_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  slp_miss_timer #(
    .MISS_LAT (MISS_LAT),
    .REM_W    (REM_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .miss_start (miss_start),
    .pend_q     (pend_q),
    .pend_d     (pend_d),
    .rem_q      (rem_q),
    .rem_d      (rem_d)
  );

  slp_idle_mon #(
    .IDLE_K (IDLE_K),
    .IDLE_W (IDLE_W)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pend_q   (pend_q),
    .iq_issue (iq_issue),
    .fu_exec  (fu_exec),
    .idle_q   (idle_q),
    .idle_d   (idle_d)
  );

  slp_sleep_ctl #(
    .IDLE_K    (IDLE_K),
    .MISS_LAT  (MISS_LAT),
    .WAKE_LEAD (WAKE_LEAD),
    .IDLE_W    (IDLE_W),
    .REM_W     (REM_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pend_d    (pend_d),
    .idle_d    (idle_d),
    .rem_d     (rem_d),
    .sleep     (sleep),
    .wake_done (wake_done)
  );
endmodule

// File: rtl/cache_sleep_chk.sv
module cache_sleep_chk #(
  parameter int IDLE_K    = 10,
  parameter int MISS_LAT  = 300,
  parameter int WAKE_LEAD = 10,
  parameter int IDLE_W    = 4,
  parameter int REM_W     = 9
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              miss_start,
  input logic              iq_issue,
  input logic              fu_exec,
  input logic              sleep,
  input logic              wake_done,
  input logic              pend_q,
  input logic [IDLE_W-1:0] idle_q,
  input logic [REM_W-1:0]  rem_q
);
  localparam logic [IDLE_W-1:0] K_V    = IDLE_W'(IDLE_K);
  localparam logic [REM_W-1:0]  LAT_V  = REM_W'(MISS_LAT);
  localparam logic [REM_W-1:0]  LEAD_V = REM_W'(WAKE_LEAD);

  assert_sleep_needs_miss_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    sleep |-> pend_q);

  assert_enter_at_threshold_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sleep) |-> (idle_q == K_V));

  assert_lead_kept_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    sleep |-> (rem_q > LEAD_V));

  assert_restart_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    miss_start |=> (rem_q == LAT_V));

  assert_activity_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sleep && (iq_issue || fu_exec)) |=> !sleep);

  assert_pulse_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    wake_done |-> (!sleep && $past(sleep)));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    wake_done |=> !wake_done);
endmodule

bind cache_sleep_ctrl cache_sleep_chk #(
  .IDLE_K    (IDLE_K),
  .MISS_LAT  (MISS_LAT),
  .WAKE_LEAD (WAKE_LEAD),
  .IDLE_W    (IDLE_W),
  .REM_W     (REM_W)
) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .miss_start (miss_start),
  .iq_issue   (iq_issue),
  .fu_exec    (fu_exec),
  .sleep      (sleep),
  .wake_done  (wake_done),
  .pend_q     (pend_q),
  .idle_q     (idle_q),
  .rem_q      (rem_q)
);

// File: tb/sim_cache_sleep_ctrl.sv
module sim_cache_sleep_ctrl;
  localparam int CLK_P = 10;
  localparam int K     = 10;
  localparam int LAT   = 300;
  localparam int LEAD  = 10;
  localparam int FALL  = LAT - LEAD;

  logic clk, rst_n, miss_start, iq_issue, fu_exec;
  logic sleep, wake_done;
  int   n_run, n_fail;

  cache_sleep_ctrl #(
    .IDLE_K    (K),
    .MISS_LAT  (LAT),
    .WAKE_LEAD (LEAD)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_start (miss_start),
    .iq_issue   (iq_issue),
    .fu_exec    (fu_exec),
    .sleep      (sleep),
    .wake_done  (wake_done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive inputs for one cycle; return just after the sampling edge.
  task automatic step(input logic ms, input logic iss, input logic ex);
    miss_start = ms; iq_issue = iss; fu_exec = ex;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; miss_start = 0; iq_issue = 0; fu_exec = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "sleep in reset", 32'(sleep), 0);
    chk("R10", "wake_done in reset", 32'(wake_done), 0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0);
  endtask

  task automatic t_no_miss;
    for (int j = 1; j <= 40; j++) begin
      step(0, 0, 0);
      chk("R1", $sformatf("sleep idle without miss j=%0d", j), 32'(sleep), 0);
    end
  endtask

  task automatic t_basic;
    step(1, 0, 0);
    for (int j = 1; j <= LAT + 20; j++) begin
      string rq;
      step(0, 0, 0);
      rq = (j >= LAT) ? "R11" : (j >= FALL) ? "R5" : "R3";
      chk(rq, $sformatf("basic sleep j=%0d", j), 32'(sleep),
          32'((j >= K) && (j < FALL)));
      chk("R9", $sformatf("basic wake j=%0d", j), 32'(wake_done), 32'(j == FALL));
    end
  endtask

  task automatic t_restart_count;
    step(1, 0, 0);
    for (int j = 1; j <= LAT + 5; j++) begin
      step(0, 0, (j == 10));
      chk("R4", $sformatf("exec-only restart sleep j=%0d (R2)", j), 32'(sleep),
          32'((j >= 20) && (j < FALL)));
      chk("R9", $sformatf("restart wake j=%0d", j), 32'(wake_done), 32'(j == FALL));
    end
  endtask

  task automatic t_late_threshold;
    step(1, 0, 0);
    for (int j = 1; j <= LAT + 5; j++) begin
      step(0, (j <= 285) && (j % 2 == 0), (j <= 285) && (j % 2 == 1));
      chk("R6", $sformatf("late threshold sleep j=%0d", j), 32'(sleep), 0);
    end
  endtask

  task automatic t_second_miss;
    step(1, 0, 0);
    for (int j = 1; j <= 100 + LAT + 10; j++) begin
      step((j == 100), 0, 0);
      chk("R7", $sformatf("second miss sleep j=%0d", j), 32'(sleep),
          32'((j >= K) && (j < 100 + FALL)));
      chk("R9", $sformatf("second miss wake j=%0d", j), 32'(wake_done),
          32'(j == 100 + FALL));
    end
  endtask

  task automatic t_wake_on_activity;
    step(1, 0, 0);
    for (int j = 1; j <= LAT + 5; j++) begin
      step(0, (j == 51), 0);
      chk("R8", $sformatf("issue while asleep sleep j=%0d (R2)", j), 32'(sleep),
          32'(((j >= K) && (j <= 50)) || ((j >= 61) && (j < FALL))));
      chk("R9", $sformatf("activity wake j=%0d", j), 32'(wake_done),
          32'((j == 51) || (j == FALL)));
    end
  endtask

  task automatic t_reset_mid_sleep;
    step(1, 0, 0);
    for (int j = 1; j <= 30; j++) step(0, 0, 0);
    chk("R3", "asleep before reset", 32'(sleep), 1);
    rst_n = 1'b0;
    #1;
    chk("R10", "sleep drops on reset", 32'(sleep), 0);
    chk("R10", "wake_done low on reset", 32'(wake_done), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int j = 1; j <= 40; j++) begin
      step(0, 0, 0);
      chk("R10", $sformatf("no miss kept after reset j=%0d", j), 32'(sleep), 0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    t_reset();
    t_no_miss();
    t_basic();
    t_restart_count();
    t_late_threshold();
    t_second_miss();
    t_wake_on_activity();
    t_reset_mid_sleep();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule